// File: doc/BRIEF.md
# Split Translation Lookup Engine

This block stores address translation entries and finds the one that covers a given 48-bit virtual address for the current address-space identifier. Its storage has two regions. The first is a set-associative region of 8 ways by 256 sets, and all of its entries use one page size that comes from a configuration input. The second is a small fully associative region of 64 entries, and each of these carries its own page size. Every entry maps an aligned pair of adjacent pages (an even page and an odd page), so the compared page number is the address shifted right by the page-size exponent plus one.

A lookup is a multi-cycle scan. It examines one set-associative way per cycle, from way 0 to way 7, and then one fully associative entry per cycle, from entry 0 to entry 63. It stops at the first match and pulses `done` with the hit flag and the matching entry index. Entries are loaded through a write port that accepts only while the engine is idle, so a search always sees a stable table. Permission checks, refill and page walking belong to other blocks.

Top module: `tlb_split_lookup`

## Requirements
- R1: A write stores the tag word `wrTag` fields by bit position: bit 0 = exist, bits 10:1 = ASID, bits 47:13 = VPPN (virtual address bits 47:13), bits 53:48 = page-size exponent. Bits 12:11 and 63:54 are ignored. The global flag comes from `wrGlobal`. An entry whose exist bit is 0 never matches.
- R2: Each entry covers a page pair. An address matches when its bits above position (page size + 1) equal the same bits of the stored VPPN shifted back to bit 13, so both the even page and the odd page of the pair hit the same entry.
- R3: The set-associative entries use the `pageSize` value sampled when the request is accepted. The set is bits 7:0 of (address >> (pageSize + 1)). Way w, set s is entry index w*256 + s.
- R4: The fully associative entries are indices 2048 to 2111. Each one compares with its own stored page-size field and ignores `pageSize`.
- R5: An entry matches only if it exists, its page number matches, and either its global flag is set or its ASID equals `reqAsid`.
- R6: All set-associative ways are searched before any fully associative entry. Within each region the lowest way or lowest index wins.
- R7: `done` is high for exactly one cycle per accepted request. Counting clock edges from the accepting edge, it rises after w+1 edges for a hit in way w, after 9+k edges for a hit in fully associative entry k, and after 72 edges for a miss. On a miss `hit` is 0 and `hitIdx` is 0.
- R8: `reqReady` is low while a search runs. A request raised during a search is ignored and produces no `done`.
- R9: `wrReady` is low while a search runs. A write offered then waits until the engine is idle, and it cannot change the result of the search in progress.
- R10: After reset no entry exists, `reqReady` and `wrReady` are 1, and `done` and `hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Lookup request |
| reqReady | output | 1 | Engine idle; a request is accepted |
| reqVa | input | 48 | Virtual address to translate |
| reqAsid | input | 10 | Current address-space identifier |
| pageSize | input | 6 | Page-size exponent shared by the set-associative region |
| wrEn | input | 1 | Entry write request, held until accepted |
| wrReady | output | 1 | Write is accepted at this edge |
| wrIdx | input | 12 | Entry index to write (0 to 2111) |
| wrTag | input | 64 | Tag word for the entry |
| wrGlobal | input | 1 | Global flag for the entry |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Result: a matching entry was found |
| hitIdx | output | 12 | Index of the matching entry |

## Verification
The bench aims at priority. It places the same page in two ways, in two fully associative entries, and in both regions at once. A scan that runs in the wrong order, or that does not stop at the first match, reports a higher index. It also covers the odd page of a pair, the next pair up, a change of the shared page size, and a large fully associative page hit deep inside its range. A design that shifts by the page size without the extra pair bit, or that uses the wrong region's page size, turns these hits into misses or misses into hits. Result latency is measured against the scan position, so a scan that skips or repeats a slot shows up even when the index is right. During a long miss search the bench raises a second request and a write that would match. A design that lets either one through produces a stray result or turns the miss into a hit.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
  parameter int VA_W   = 48;
  parameter int ASID_W = 10;
  parameter int PS_W   = 6;
  parameter int WAYS   = 8;
  parameter int SETS   = 256;
  parameter int FA_N   = 64;
  parameter int TAG_W  = 64;

  localparam int SA_N     = WAYS * SETS;
  localparam int TOTAL    = SA_N + FA_N;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int SET_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);
  localparam int FA_W     = $clog2(FA_N);
  localparam int SLOT_W   = (WAY_W > FA_W) ? WAY_W : FA_W;
  localparam int SH_W     = PS_W + 1;
  localparam int VPPN_LSB = 13;
  localparam int VPPN_W   = VA_W - VPPN_LSB;
  localparam int ASID_LSB = 1;
  localparam int PS_LSB   = VA_W;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPPN_W-1:0] vppn;
    logic [PS_W-1:0]   ps;
    logic              glob;
  } entryT;

  typedef struct packed {
    logic              capture;
    logic              faPhase;
    logic [SLOT_W-1:0] slot;
    logic              finish;
    logic              finishHit;
  } strobeT;
endpackage

// File: rtl/tlbl_control.sv
module tlbl_control
  import tlbl_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   match,
  output strobeT strb,
  output logic   busy
);
  typedef enum logic [1:0] {S_IDLE, S_SA, S_FA} stateT;
  stateT state;
  logic [SLOT_W-1:0] slot;
  logic lastWay, lastFa;

  assign lastWay = (slot == SLOT_W'(WAYS - 1));
  assign lastFa  = (slot == SLOT_W'(FA_N - 1));
  assign busy    = (state != S_IDLE);

  always_comb begin
    strb.capture   = reqValid && (state == S_IDLE);
    strb.faPhase   = (state == S_FA);
    strb.slot      = slot;
    strb.finish    = ((state == S_SA) && match) ||
                     ((state == S_FA) && (match || lastFa));
    strb.finishHit = busy && match;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      slot  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          state <= S_SA;
          slot  <= '0;
        end
        S_SA: begin
          if (match) begin
            state <= S_IDLE;
          end else if (lastWay) begin
            state <= S_FA;
            slot  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        S_FA: begin
          if (match || lastFa) state <= S_IDLE;
          else slot <= slot + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: the fully associative scan starts only after the last way
  a_r6_fa_after_last_way: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FA && $past(state) == S_SA) |-> $past(slot) == SLOT_W'(WAYS - 1));

  // R7: a finishing scan returns to idle
  a_r7_finish_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> state == S_IDLE);
endmodule

// File: rtl/tlbl_datapath.sv
module tlbl_datapath
  import tlbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              busy,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [PS_W-1:0]   pageSize,
  input  logic              wrFire,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              wrGlobal,
  output logic              match,
  output logic              doneQ,
  output logic              hitQ,
  output logic [IDX_W-1:0]  hitIdxQ
);
  logic [TOTAL-1:0] validVec;
  entryT            mem [TOTAL];

  logic [VA_W-1:0]   vaQ;
  logic [ASID_W-1:0] asidQ;
  logic [PS_W-1:0]   psQ;
  logic [SET_W-1:0]  setQ;

  logic [IDX_W-1:0] curIdx;
  entryT            curEnt;
  logic [PS_W-1:0]  effPs;
  logic [SH_W-1:0]  shAmt, reqSh;
  logic [VA_W-1:0]  vaVpn, tagVpn;
  logic             wrInRange;
  logic             unusedTagBits;

  assign unusedTagBits = ^{wrTag[TAG_W-1:PS_LSB+PS_W], wrTag[VPPN_LSB-1:ASID_LSB+ASID_W]};
  assign reqSh         = {1'b0, pageSize} + SH_W'(1);
  assign wrInRange     = (int'(wrIdx) < TOTAL);

  // Request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ   <= '0;
      asidQ <= '0;
      psQ   <= '0;
      setQ  <= '0;
    end else if (strb.capture) begin
      vaQ   <= reqVa;
      asidQ <= reqAsid;
      psQ   <= pageSize;
      setQ  <= SET_W'(reqVa >> reqSh);
    end
  end

  // Scan slot to entry index
  always_comb begin
    if (strb.faPhase)
      curIdx = IDX_W'(SA_N) + IDX_W'(strb.slot);
    else
      curIdx = IDX_W'(strb.slot[WAY_W-1:0]) * IDX_W'(SETS) + IDX_W'(setQ);
  end

  // Compare one entry
  always_comb begin
    curEnt = mem[curIdx];
    effPs  = strb.faPhase ? curEnt.ps : psQ;
    shAmt  = {1'b0, effPs} + SH_W'(1);
    vaVpn  = vaQ >> shAmt;
    tagVpn = {curEnt.vppn, {VPPN_LSB{1'b0}}} >> shAmt;
    match  = validVec[curIdx] && (vaVpn == tagVpn) &&
             (curEnt.glob || (curEnt.asid == asidQ));
  end

  // Entry storage
  always_ff @(posedge clk) begin
    if (wrFire && wrInRange)
      mem[wrIdx] <= '{asid: wrTag[ASID_LSB +: ASID_W],
                      vppn: wrTag[VPPN_LSB +: VPPN_W],
                      ps:   wrTag[PS_LSB +: PS_W],
                      glob: wrGlobal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validVec <= '0;
    else if (wrFire && wrInRange) validVec[wrIdx] <= wrTag[0];
  end

  // Result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ   <= 1'b0;
      hitQ    <= 1'b0;
      hitIdxQ <= '0;
    end else begin
      doneQ <= strb.finish;
      if (strb.finish) begin
        hitQ    <= strb.finishHit;
        hitIdxQ <= strb.finishHit ? curIdx : '0;
      end
    end
  end

  // R7: the result strobe lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: the table does not change while a search runs
  a_r9_table_stable_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(validVec));

  // R5: a reported hit names an existing entry
  a_r5_hit_exists: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && hitQ) |-> validVec[hitIdxQ]);

  // R4: a reported index lies inside the table
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && hitQ) |-> (int'(hitIdxQ) < TOTAL));
endmodule

// File: rtl/tlb_split_lookup.sv
module tlb_split_lookup
  import tlbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [PS_W-1:0]   pageSize,
  input  logic              wrEn,
  output logic              wrReady,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              wrGlobal,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx
);
  strobeT strb;
  logic   busy, match;

  assign reqReady = !busy;
  assign wrReady  = !busy;

  tlbl_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .match(match),
    .strb(strb), .busy(busy)
  );

  tlbl_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .reqVa(reqVa), .reqAsid(reqAsid), .pageSize(pageSize),
    .wrFire(wrEn && !busy), .wrIdx(wrIdx), .wrTag(wrTag), .wrGlobal(wrGlobal),
    .match(match), .doneQ(done), .hitQ(hit), .hitIdxQ(hitIdx)
  );

  // R8: no request is accepted during a search, and a result means the engine is idle
  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);
endmodule

// File: tb/tlb_split_lookup_test.sv
module tlb_split_lookup_test;
  import tlbl_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0, reqReady;
  logic [VA_W-1:0]   reqVa = '0;
  logic [ASID_W-1:0] reqAsid = '0;
  logic [PS_W-1:0]   pageSize = '0;
  logic              wrEn = 1'b0, wrReady, wrGlobal = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [TAG_W-1:0]  wrTag = '0;
  logic              done, hit;
  logic [IDX_W-1:0]  hitIdx;

  tlb_split_lookup uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAsid(reqAsid), .pageSize(pageSize),
    .wrEn(wrEn), .wrReady(wrReady), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrGlobal(wrGlobal), .done(done), .hit(hit), .hitIdx(hitIdx)
  );

  int errors = 0, checks = 0, cyc = 0, doneSeen = 0, lookups = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference table
  logic        mValid [TOTAL];
  logic [63:0] mTag   [TOTAL];
  logic        mGlob  [TOTAL];

  typedef struct {
    logic  hit;
    int    idx;
    int    lat;
    int    acc;
    string req;
  } expT;
  expT sb[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkTag(logic e, logic [9:0] asid, logic [47:0] va, logic [5:0] ps);
    return {10'b0, ps, va[47:13], 2'b0, asid, e};
  endfunction

  function automatic int saIdx(int w, logic [47:0] va, logic [5:0] ps);
    return w * SETS + int'((va >> (int'(ps) + 1)) & 48'hFF);
  endfunction

  function automatic logic entMatch(int e, logic [47:0] va, logic [9:0] asid, int ps);
    logic [47:0] tv;
    if (!mValid[e]) return 1'b0;
    tv = {mTag[e][47:13], 13'b0};
    if (((va ^ tv) >> (ps + 1)) != 0) return 1'b0;
    return mGlob[e] || (mTag[e][10:1] == asid);
  endfunction

  function automatic expT model(logic [47:0] va, logic [9:0] asid, logic [5:0] ps);
    expT r;
    r.hit = 1'b0; r.idx = 0; r.lat = WAYS + FA_N;
    for (int w = WAYS - 1; w >= 0; w--)
      if (entMatch(saIdx(w, va, ps), va, asid, int'(ps))) begin
        r.hit = 1'b1; r.idx = saIdx(w, va, ps); r.lat = w + 1;
      end
    if (!r.hit)
      for (int k = FA_N - 1; k >= 0; k--)
        if (entMatch(SA_N + k, va, asid, int'(mTag[SA_N + k][53:48]))) begin
          r.hit = 1'b1; r.idx = SA_N + k; r.lat = WAYS + k + 1;
        end
    return r;
  endfunction

  task automatic wr(int idx, logic [63:0] tag, logic g);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrTag = tag; wrGlobal = g;
    while (!wrReady) @(negedge clk);
    @(posedge clk); #1;
    wrEn = 1'b0;
    mValid[idx] = tag[0]; mTag[idx] = tag; mGlob[idx] = g;
  endtask

  task automatic lookup(string req, logic [47:0] va, logic [9:0] asid, logic [5:0] ps);
    expT e;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAsid = asid; pageSize = ps;
    @(posedge clk); #1;
    reqValid = 1'b0;
    e = model(va, asid, ps);
    e.acc = cyc; e.req = req;
    sb.push_back(e);
    lookups++;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: compare each result with the scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      doneSeen++;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: stray done actual 1 expected 0");
      end else begin
        expT e;
        e = sb.pop_front();
        chk({e.req, " hit"}, 64'(hit), 64'(e.hit));
        chk({e.req, " index"}, 64'(hitIdx), 64'(e.idx));
        chk({e.req, " R7 latency"}, 64'(cyc - e.acc), 64'(e.lat));
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [47:0] VA_A = 48'h0000_1234_8000;
  localparam logic [47:0] VA_B = 48'h0000_5670_0000;
  localparam logic [47:0] VA_C = 48'h0000_0ABC_0000;
  localparam logic [47:0] VA_D = 48'h0000_4040_0000;
  localparam logic [47:0] VA_E = 48'h0000_7777_0000;
  localparam logic [47:0] VA_F = 48'h0000_3210_8000;

  initial begin
    for (int i = 0; i < TOTAL; i++) begin
      mValid[i] = 1'b0; mTag[i] = '0; mGlob[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reqReady", 64'(reqReady), 1);
    chk("R10 wrReady", 64'(wrReady), 1);
    chk("R10 done", 64'(done), 0);
    chk("R10 hit", 64'(hit), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 / R7: empty table misses after the full scan
    lookup("R10 empty miss", VA_A, 10'd5, 6'd14);

    // R3 / R1: set-associative hit in way 3
    wr(saIdx(3, VA_A, 6'd14), mkTag(1'b1, 10'd5, VA_A, 6'd0), 1'b0);
    lookup("R3 way3 hit", VA_A, 10'd5, 6'd14);
    // R2: odd page of the pair hits, next pair misses
    lookup("R2 odd page", VA_A + 48'h4000, 10'd5, 6'd14);
    lookup("R2 next pair", VA_A + 48'h8000, 10'd5, 6'd14);
    // R5: ASID mismatch misses, global entry ignores ASID
    lookup("R5 asid mismatch", VA_A, 10'd6, 6'd14);
    wr(saIdx(4, VA_B, 6'd14), mkTag(1'b1, 10'd1, VA_B, 6'd0), 1'b1);
    lookup("R5 global hit", VA_B, 10'd9, 6'd14);
    // R6: lowest way wins
    wr(saIdx(6, VA_C, 6'd14), mkTag(1'b1, 10'd2, VA_C, 6'd0), 1'b0);
    wr(saIdx(1, VA_C, 6'd14), mkTag(1'b1, 10'd2, VA_C, 6'd0), 1'b0);
    lookup("R6 way priority", VA_C, 10'd2, 6'd14);
    // R4 / R6: fully associative, own page size, lowest index wins
    wr(SA_N + 10, mkTag(1'b1, 10'd3, VA_D, 6'd21), 1'b0);
    wr(SA_N + 3,  mkTag(1'b1, 10'd3, VA_D, 6'd21), 1'b0);
    lookup("R4 fa hit", VA_D, 10'd3, 6'd14);
    lookup("R4 fa large page", VA_D + 48'h30_0000, 10'd3, 6'd14);
    // R6: set-associative region beats fully associative
    wr(saIdx(7, VA_D, 6'd14), mkTag(1'b1, 10'd3, VA_D, 6'd0), 1'b0);
    lookup("R6 region priority", VA_D, 10'd3, 6'd14);
    // R3: shared page size change moves the set
    lookup("R3 shared size change", VA_A, 10'd5, 6'd16);
    // R4: a small fully associative page does not cover the next pair
    wr(SA_N + 20, mkTag(1'b1, 10'd4, VA_E, 6'd14), 1'b0);
    lookup("R4 fa own size hit", VA_E, 10'd4, 6'd21);
    lookup("R4 fa own size miss", VA_E + 48'h8000, 10'd4, 6'd21);
    // R1: clearing the exist bit removes the entry
    wr(saIdx(3, VA_A, 6'd14), mkTag(1'b0, 10'd5, VA_A, 6'd0), 1'b0);
    lookup("R1 exist clear", VA_A, 10'd5, 6'd14);

    // R8 / R9: request and write offered during a search
    fork
      lookup("R9 search unaffected", VA_F, 10'd2, 6'd14);
      begin
        repeat (5) @(negedge clk);
        chk("R8 reqReady busy", 64'(reqReady), 0);
        chk("R9 wrReady busy", 64'(wrReady), 0);
        reqValid = 1'b1; reqVa = VA_B; reqAsid = 10'd9;
        @(negedge clk);
        reqValid = 1'b0;
        wr(saIdx(2, VA_F, 6'd14), mkTag(1'b1, 10'd2, VA_F, 6'd0), 1'b0);
      end
    join
    repeat (4) @(negedge clk);
    chk("R8 result count", 64'(doneSeen), 64'(lookups));
    lookup("R9 held write landed", VA_F, 10'd2, 6'd14);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule